// File: doc/BRIEF.md
# Keyboard Controller Host Interface

This block is the host-facing half of a PC-style keyboard controller. The host sees two byte-wide locations selected by one address bit. Address 0 is the data location. Address 1 is the command location when written and the status byte when read. Every byte the host writes lands in a single input buffer, and a status flag records which address it came through. The controller takes the byte on the following clock. It either executes it as a command or hands it to a command that is waiting for a data byte.

Commands can read or write a 32-byte internal RAM and return a byte through the output buffer. They can also read the input port, or read and write an output port. That output port carries the system reset line on bit 0 and the A20 gate on bit 1. Another group of commands drives chosen low bits of the output port low for 6 microseconds. That time is counted in clock cycles derived from a clock-frequency parameter. RAM byte 0 holds the configuration: bit 0 enables the output-buffer-full interrupt and bit 4 disables the keyboard.

Top module: `kbc_host_if`

## Requirements
- R1: After reset the status byte reads 0x10, `out_port` equals the parameter `OUTP_RST` (default 0xC1), `irq` is 0, `kbd_off` is 0 and every RAM byte is 0.
- R2: An accepted host write sets status bit 1 for exactly one cycle. Status bit 3 then shows 1 for a write to address 1 (command) and 0 for a write to address 0 (data).
- R3: Commands 0x20..0x3F place the RAM byte at the command's low 5 bits into the output buffer and set status bit 0.
- R4: Commands 0x60..0x7F store the next data byte at the RAM byte given by the command's low 5 bits. A command byte that arrives first cancels the pending store, and the later data byte is discarded.
- R5: Command 0xAA places 0x55 in the output buffer and sets status bit 2. Bit 2 then stays set until reset.
- R6: Command 0xAB returns an interface test code. The clock line is compared with `out_port` bit 6 and the data line with `out_port` bit 7. A clock mismatch returns 1 (line low) or 2 (line high). Otherwise a data mismatch returns 3 (line low) or 4 (line high). Otherwise the code is 0.
- R7: Command 0xAD sets RAM byte 0 bit 4 and 0xAE clears it. `kbd_off` follows that bit, and status bit 4 is its inverse.
- R8: Command 0xC0 returns `in_port`, 0xD0 returns the output port register, and 0xD1 writes the next data byte to the output port.
- R9: Command 0xDD clears `out_port` bit 1 and 0xDF sets it, leaving the other bits unchanged.
- R10: Commands 0xF0..0xFF drive low each `out_port` bit among bits 0..3 whose bit in the command's low nibble is 0. The low level lasts exactly `PULSE_US`·`CLK_HZ`/10^6 cycles (1500 by default). 0xFF pulses nothing and starts no pulse.
- R11: Host writes are discarded while a pulse is active: status bit 1 stays 0 and the byte has no effect.
- R12: A host read of address 0 returns the output buffer and clears status bit 0. `irq` is high while status bit 0 and RAM byte 0 bit 0 are both set.
- R13: An unrecognised command byte, or a data byte with no command waiting, is consumed with no effect. The output buffer and its flag are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Host chip select |
| addr | input | 1 | 0 = data location, 1 = command/status location |
| wr | input | 1 | Host write strobe (with cs) |
| rd | input | 1 | Host read strobe (with cs) |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Output buffer (addr 0) or status byte (addr 1) |
| in_port | input | 8 | Input port value returned by 0xC0 |
| line_clk | input | 1 | Sensed keyboard clock line, used by 0xAB |
| line_dat | input | 1 | Sensed keyboard data line, used by 0xAB |
| out_port | output | 8 | Output port, including pulse masking |
| irq | output | 1 | Output-buffer-full interrupt |
| kbd_off | output | 1 | Keyboard disabled (RAM byte 0 bit 4) |

## Verification
A host write is captured on the clock edge where `wr` is high. The input-buffer flag and the command/data flag are visible one cycle after that edge. Command results appear one cycle after that: output buffer, flags, RAM, output port and pulse start. A host read of address 0 clears the output-buffer flag on its own edge. The bench drives inputs and samples on falling edges. It checks the status byte at both points of every write, and counts the pulse length at each falling edge after the command takes effect.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_RAM  = 2'd1,
    PEND_OUTP = 2'd2
  } pend_e;

  // interface test: compare driven line levels with sensed levels
  function automatic logic [BYTE_W-1:0] ift_code(input logic drv_clk, input logic drv_dat,
                                                 input logic sen_clk, input logic sen_dat);
    logic [BYTE_W-1:0] code;
    if (drv_clk != sen_clk)      code = sen_clk ? 8'd2 : 8'd1;
    else if (drv_dat != sen_dat) code = sen_dat ? 8'd4 : 8'd3;
    else                         code = 8'd0;
    return code;
  endfunction

endpackage

// File: rtl/kbc_ram.sv
module kbc_ram #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] byte0
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic wen;
    assign wen = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '0;
      else if (wen) mem_q[g] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
  assign byte0 = mem_q[0];

endmodule

// File: rtl/kbc_pulse_timer.sv
module kbc_pulse_timer #(
  parameter int unsigned CYC = 1500,
  parameter int unsigned MW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [MW-1:0] mask_in,
  output logic          active,
  output logic [MW-1:0] mask
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic [MW-1:0] mask_q, mask_d;

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    mask_d = mask_q;
    if (start) begin
      act_d  = 1'b1;
      cnt_d  = CW'(CYC - 1);
      mask_d = mask_in;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      mask_q <= mask_d;
    end
  end

  assign active = act_q;
  assign mask   = mask_q;

  AST_PULSE_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> !start) else $error("pulse restarted while active"); // R11

endmodule

// File: rtl/kbc_cmd_unit.sv
module kbc_cmd_unit
  import kbc_pkg::*;
#(
  parameter int unsigned AW       = 5,
  parameter logic [7:0]  OUTP_RST = 8'hC1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          consume,
  input  logic [7:0]    in_byte,
  input  logic          is_cmd,
  input  logic [7:0]    ram_rdata,
  input  logic [7:0]    ram0,
  input  logic [7:0]    in_port,
  input  logic          line_clk,
  input  logic          line_dat,
  output logic [AW-1:0] ram_raddr,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [7:0]    ram_wdata,
  output logic          resp_valid,
  output logic [7:0]    resp_data,
  output logic [7:0]    outp,
  output logic          sysflag,
  output logic          pulse_start,
  output logic [3:0]    pulse_mask
);
  pend_e         pend_q, pend_d;
  logic [AW-1:0] paddr_q, paddr_d;
  logic [7:0]    outp_q, outp_d;
  logic          sys_q, sys_d;

  assign ram_raddr = in_byte[AW-1:0];

  always_comb begin
    pend_d      = pend_q;
    paddr_d     = paddr_q;
    outp_d      = outp_q;
    sys_d       = sys_q;
    ram_we      = 1'b0;
    ram_waddr   = paddr_q;
    ram_wdata   = in_byte;
    resp_valid  = 1'b0;
    resp_data   = '0;
    pulse_start = 1'b0;
    pulse_mask  = ~in_byte[3:0];
    if (consume) begin
      pend_d = PEND_NONE;
      if (!is_cmd) begin
        unique case (pend_q)
          PEND_RAM:  ram_we = 1'b1;
          PEND_OUTP: outp_d = in_byte;
          default: ;
        endcase
      end else begin
        casez (in_byte)
          8'b001?????: begin resp_valid = 1'b1; resp_data = ram_rdata; end
          8'b011?????: begin pend_d = PEND_RAM; paddr_d = in_byte[AW-1:0]; end
          8'hAA: begin resp_valid = 1'b1; resp_data = 8'h55; sys_d = 1'b1; end
          8'hAB: begin
            resp_valid = 1'b1;
            resp_data  = ift_code(outp_q[6], outp_q[7], line_clk, line_dat);
          end
          8'hAD: begin ram_we = 1'b1; ram_waddr = '0; ram_wdata = ram0 | 8'h10; end
          8'hAE: begin ram_we = 1'b1; ram_waddr = '0; ram_wdata = ram0 & 8'hEF; end
          8'hC0: begin resp_valid = 1'b1; resp_data = in_port; end
          8'hD0: begin resp_valid = 1'b1; resp_data = outp_q; end
          8'hD1: pend_d = PEND_OUTP;
          8'hDD: outp_d[1] = 1'b0;
          8'hDF: outp_d[1] = 1'b1;
          8'b1111????: pulse_start = (in_byte[3:0] != 4'hF);
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= PEND_NONE;
      paddr_q <= '0;
      outp_q  <= OUTP_RST;
      sys_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      paddr_q <= paddr_d;
      outp_q  <= outp_d;
      sys_q   <= sys_d;
    end
  end

  assign outp    = outp_q;
  assign sysflag = sys_q;

  AST_SYSFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sys_q |=> sys_q) else $error("system flag dropped"); // R5
  AST_OUTP_ONLY_ON_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
    !consume |=> $stable(outp_q)) else $error("output port changed without a byte"); // R8

endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 250_000_000,
  parameter int unsigned PULSE_US = 6,
  parameter int unsigned RAM_AW   = 5,
  parameter logic [7:0]  OUTP_RST = 8'hC1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] in_port,
  input  logic       line_clk,
  input  logic       line_dat,
  output logic [7:0] out_port,
  output logic       irq,
  output logic       kbd_off
);
  localparam int unsigned PULSE_RAW = (CLK_HZ / 1_000_000) * PULSE_US;
  localparam int unsigned PULSE_CYC = (PULSE_RAW == 0) ? 1 : PULSE_RAW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic       ibf_q, ibf_d, cd_q, cd_d, obf_q, obf_d;
  logic [7:0] ibuf_q, ibuf_d, obuf_q, obuf_d;
  logic       host_wr, host_rd_data, accept;

  logic [RAM_AW-1:0] ram_raddr, ram_waddr;
  logic              ram_we;
  logic [7:0]        ram_wdata, ram_rdata, ram0;
  logic              resp_valid, sysflag, pulse_start, pulse_active;
  logic [7:0]        resp_data, outp;
  logic [3:0]        pulse_mask_in, pulse_mask;

  assign host_wr      = cs && wr;
  assign host_rd_data = cs && rd && !addr;
  assign accept       = host_wr && !ibf_q && !pulse_active;

  always_comb begin
    ibf_d  = accept;
    cd_d   = accept ? addr : cd_q;
    ibuf_d = accept ? wdata : ibuf_q;
    obf_d  = obf_q;
    obuf_d = obuf_q;
    if (resp_valid) begin
      obf_d  = 1'b1;
      obuf_d = resp_data;
    end else if (host_rd_data) begin
      obf_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ibf_q  <= 1'b0;
      cd_q   <= 1'b0;
      ibuf_q <= '0;
      obf_q  <= 1'b0;
      obuf_q <= '0;
    end else begin
      ibf_q  <= ibf_d;
      cd_q   <= cd_d;
      ibuf_q <= ibuf_d;
      obf_q  <= obf_d;
      obuf_q <= obuf_d;
    end
  end

  kbc_ram #(.AW(RAM_AW), .DW(BYTE_W)) i_ram (
    .clk(clk), .rst_n(rst_ni), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata), .byte0(ram0)
  );

  kbc_cmd_unit #(.AW(RAM_AW), .OUTP_RST(OUTP_RST)) i_cmd (
    .clk(clk), .rst_n(rst_ni), .consume(ibf_q), .in_byte(ibuf_q), .is_cmd(cd_q),
    .ram_rdata(ram_rdata), .ram0(ram0), .in_port(in_port),
    .line_clk(line_clk), .line_dat(line_dat),
    .ram_raddr(ram_raddr), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .resp_valid(resp_valid), .resp_data(resp_data), .outp(outp), .sysflag(sysflag),
    .pulse_start(pulse_start), .pulse_mask(pulse_mask_in)
  );

  kbc_pulse_timer #(.CYC(PULSE_CYC), .MW(4)) i_pulse (
    .clk(clk), .rst_n(rst_ni), .start(pulse_start), .mask_in(pulse_mask_in),
    .active(pulse_active), .mask(pulse_mask)
  );

  assign out_port = outp & ~{4'b0000, (pulse_active ? pulse_mask : 4'b0000)};
  assign rdata    = addr ? {3'b000, ~ram0[4], cd_q, sysflag, ibf_q, obf_q} : obuf_q;
  assign irq      = obf_q && ram0[0];
  assign kbd_off  = ram0[4];

  AST_IBF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    ibf_q |=> !ibf_q) else $error("input byte not consumed"); // R2
  AST_NO_WRITE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    (host_wr && pulse_active) |=> !ibf_q) else $error("write taken during pulse"); // R11
  AST_OBF_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_ni)
    (host_rd_data && !resp_valid) |=> !obf_q) else $error("read left buffer full"); // R12
  AST_PORT_FROZEN_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    (pulse_active && $past(pulse_active)) |-> $stable(out_port)) else $error("port moved mid-pulse"); // R10

endmodule

// File: tb/test_kbc_host_if.sv
module test_kbc_host_if;

  localparam int unsigned PULSE_CYC = 1500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] in_port = 8'hA5;
  logic       line_clk = 1'b1, line_dat = 1'b1;
  logic [7:0] rdata, out_port;
  logic       irq, kbd_off;

  int unsigned vectors = 0;
  int unsigned errors  = 0;

  always #2 clk = ~clk;

  kbc_host_if i_kbc_host_if (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
    .rdata(rdata), .in_port(in_port), .line_clk(line_clk), .line_dat(line_dat),
    .out_port(out_port), .irq(irq), .kbd_off(kbd_off)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic peek(input logic a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  // write, check flags after capture edge and after the consume edge
  task automatic wr_byte(input logic a, input logic [7:0] d, input bit acc, input string tag);
    logic [7:0] st;
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    peek(1'b1, st);
    check({tag, " ibf set"}, {7'b0, st[1]}, {7'b0, acc});
    if (acc) check("R2 cmd/data flag", {7'b0, st[3]}, {7'b0, a});
    @(negedge clk);
    peek(1'b1, st);
    check("R2 ibf cleared", {7'b0, st[1]}, 8'h00);
  endtask

  task automatic rd_byte(input logic a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic cmd_resp(input logic [7:0] c, input logic [7:0] exp, input string tag);
    logic [7:0] st, d;
    wr_byte(1'b1, c, 1'b1, "R2");
    peek(1'b1, st);
    check({tag, " obf set"}, {7'b0, st[0]}, 8'h01);
    rd_byte(1'b0, d);
    check(tag, d, exp);
    peek(1'b1, st);
    check("R12 obf cleared by read", {7'b0, st[0]}, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] st;
    peek(1'b1, st);
    check("R1 status", st, 8'h10);
    check("R1 out_port", out_port, 8'hC1);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 kbd_off", {7'b0, kbd_off}, 8'h00);
    cmd_resp(8'h3F, 8'h00, "R1 ram byte 31 zero");
  endtask

  task automatic t_ram();
    wr_byte(1'b1, 8'h65, 1'b1, "R2");
    wr_byte(1'b0, 8'h5A, 1'b1, "R2");
    cmd_resp(8'h25, 8'h5A, "R3 read byte 5");
    wr_byte(1'b1, 8'h7F, 1'b1, "R2");
    wr_byte(1'b0, 8'hC3, 1'b1, "R2");
    cmd_resp(8'h3F, 8'hC3, "R4 write byte 31");
    cmd_resp(8'h25, 8'h5A, "R3 byte 5 kept");
    wr_byte(1'b1, 8'h66, 1'b1, "R2");
    cmd_resp(8'h20, 8'h00, "R4 cancelling command answers");
    wr_byte(1'b0, 8'h77, 1'b1, "R2");
    cmd_resp(8'h26, 8'h00, "R4 cancelled store");
  endtask

  task automatic t_selftest();
    logic [7:0] st, d;
    wr_byte(1'b1, 8'h60, 1'b1, "R2");
    wr_byte(1'b0, 8'h01, 1'b1, "R2");
    wr_byte(1'b1, 8'hAA, 1'b1, "R2");
    peek(1'b1, st);
    check("R5 sysflag set", {7'b0, st[2]}, 8'h01);
    check("R12 irq with obf", {7'b0, irq}, 8'h01);
    rd_byte(1'b0, d);
    check("R5 self-test byte", d, 8'h55);
    check("R12 irq dropped", {7'b0, irq}, 8'h00);
    cmd_resp(8'h20, 8'h01, "R3 config byte");
    peek(1'b1, st);
    check("R5 sysflag held", {7'b0, st[2]}, 8'h01);
  endtask

  task automatic t_iftest();
    wr_byte(1'b1, 8'hD1, 1'b1, "R2");
    wr_byte(1'b0, 8'hC1, 1'b1, "R2");
    line_clk = 1'b1; line_dat = 1'b1;
    cmd_resp(8'hAB, 8'd0, "R6 code 0");
    line_clk = 1'b0;
    cmd_resp(8'hAB, 8'd1, "R6 code 1");
    line_clk = 1'b1; line_dat = 1'b0;
    cmd_resp(8'hAB, 8'd3, "R6 code 3");
    wr_byte(1'b1, 8'hD1, 1'b1, "R2");
    wr_byte(1'b0, 8'h01, 1'b1, "R2");
    check("R8 D1 writes port", out_port, 8'h01);
    line_clk = 1'b1; line_dat = 1'b1;
    cmd_resp(8'hAB, 8'd2, "R6 code 2");
    line_clk = 1'b0;
    cmd_resp(8'hAB, 8'd4, "R6 code 4");
    line_clk = 1'b1;
  endtask

  task automatic t_kbd();
    logic [7:0] st;
    wr_byte(1'b1, 8'hAD, 1'b1, "R2");
    peek(1'b1, st);
    check("R7 kbd_off set", {7'b0, kbd_off}, 8'h01);
    check("R7 status bit4 low", {7'b0, st[4]}, 8'h00);
    cmd_resp(8'h20, 8'h11, "R7 config bit4 set");
    wr_byte(1'b1, 8'hAE, 1'b1, "R2");
    peek(1'b1, st);
    check("R7 kbd_off clear", {7'b0, kbd_off}, 8'h00);
    check("R7 status bit4 high", {7'b0, st[4]}, 8'h01);
  endtask

  task automatic t_ports();
    wr_byte(1'b1, 8'hD1, 1'b1, "R2");
    wr_byte(1'b0, 8'hCD, 1'b1, "R2");
    cmd_resp(8'hD0, 8'hCD, "R8 read output port");
    cmd_resp(8'hC0, 8'hA5, "R8 read input port");
    wr_byte(1'b1, 8'hDF, 1'b1, "R2");
    check("R9 A20 set", out_port, 8'hCF);
    wr_byte(1'b1, 8'hDD, 1'b1, "R2");
    check("R9 A20 clear", out_port, 8'hCD);
    wr_byte(1'b1, 8'hDF, 1'b1, "R2");
  endtask

  task automatic t_unknown();
    logic [7:0] st, d;
    wr_byte(1'b1, 8'hAA, 1'b1, "R2");
    wr_byte(1'b1, 8'hA0, 1'b1, "R2");
    wr_byte(1'b0, 8'h12, 1'b1, "R2");
    peek(1'b1, st);
    check("R13 obf kept", {7'b0, st[0]}, 8'h01);
    check("R13 port kept", out_port, 8'hCF);
    rd_byte(1'b0, d);
    check("R13 buffer kept", d, 8'h55);
  endtask

  task automatic t_pulse();
    int unsigned low_cnt;
    wr_byte(1'b1, 8'hF5, 1'b1, "R2");
    low_cnt = 0;
    for (int i = 0; i < 3000; i++) begin
      if (out_port == 8'hC5) low_cnt++;
      @(negedge clk);
    end
    check("R10 pulse length lo", low_cnt[7:0], PULSE_CYC[7:0]);
    check("R10 pulse length hi", low_cnt[15:8], PULSE_CYC[15:8]);
    check("R10 port restored", out_port, 8'hCF);
    wr_byte(1'b1, 8'hFF, 1'b1, "R2");
    check("R10 FF no pulse", out_port, 8'hCF);
    wr_byte(1'b1, 8'hF0, 1'b1, "R10");
    check("R10 all low bits pulsed", out_port, 8'hC0);
    wr_byte(1'b1, 8'hDD, 1'b0, "R11 write ignored");
    repeat (PULSE_CYC + 100) @(negedge clk);
    check("R11 A20 untouched", out_port, 8'hCF);
    wr_byte(1'b1, 8'hDD, 1'b1, "R11 accepted after pulse");
    check("R11 later command runs", out_port, 8'hCD);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_ram();
    t_selftest();
    t_iftest();
    t_kbd();
    t_ports();
    t_unknown();
    t_pulse();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule